// File: doc/BRIEF.md
# UART register front end with receive queue

This block is the register-facing half of a UART controller. A host reaches it over a simple single-cycle read/write bus with word-aligned addresses. It holds received characters in a small circular queue and keeps the status flags. It raises a level interrupt from a raw status word and a host-written mask. It also stores the configuration words (baud divisors, line control, control, queue level select, DMA control) that a separate shifter and baud generator would use. Eight fixed identification bytes sit at the top of the 4 KiB window.

Received characters and break events arrive on a push port that offers `rx_ready`. Each write to the data word sends its low byte out on a one-cycle byte strobe. The queue can run as a 16-deep buffer or, when a line-control bit is clear, as a single holding slot. A break is stored as a tagged 11-bit entry, so software can tell it apart from a character. The bit-level shifter, baud timing and DMA transfers belong to other blocks.

Top module: `uart_regfront`

## Requirements
- R1: With line-control bit 4 set, the queue accepts pushes while it holds fewer than DEPTH (16) entries and returns entries in arrival order, wrapping its pointers modulo DEPTH; at DEPTH entries `rx_ready` is low and pushes are dropped.
- R2: With line-control bit 4 clear (the reset state), a push is accepted only while the queue is empty, and `rx_ready` is low while one entry is held.
- R3: A read of word 0 returns the oldest entry in bits 10:0 and removes it when the queue is not empty; a read of an empty queue leaves the count unchanged.
- R4: The flag word (word 6) has bit 7 TX-empty (always 1), bit 5 TX-full (always 0), bit 6 RX-full and bit 4 RX-empty. It resets to 0x90, RX-empty is high exactly when the queue is empty, and writes to the word are ignored without error.
- R5: RX-full is set by a push that fills the queue to DEPTH, or by any push while control bit 4 is set, and is cleared by any read of word 0.
- R6: Raw status bit 4 (receive) is set by a push that brings the count to the trigger level (TRIG, 1) and cleared by a pop that brings it to TRIG-1. A set in the same cycle as a clear wins.
- R7: A push with `rx_brk` high stores 0x400; a character push stores the 8-bit character zero-extended.
- R8: A write to word 0 puts bits 7:0 on `tx_byte` with `tx_strobe` high for the following cycle, and sets raw status bit 5 (transmit).
- R9: Word 14 holds the mask, word 15 reads raw status, word 16 reads raw AND mask. Writing word 17 clears each raw bit written as 1 and leaves the others. `irq` is high whenever raw AND mask is non-zero.
- R10: Words 8 (low-power divisor), 9 (integer divisor), 10 (fractional divisor), 11 (line control), 12 (control), 13 (level select) and 18 (DMA control) read back the low 16 bits written. Control resets to 0x300, level select to 0x12, the rest to 0.
- R11: Byte addresses 0xFE0 to 0xFFC read identification byte (addr-0xFE0)>>2, taken from parameter ID_BYTES (byte i in bits 8i+7:8i); default bytes in order 0x21,0x30,0x07,0x00,0x5C,0xA3,0x19,0xE4.
- R12: An access to any word other than 0, 6, 8 to 18 or the identification range reads 0, changes nothing and drives `bus_err` high for the next cycle. Word 17 reads 0; writes to words 15, 16 and the identification range are ignored without error.
- R13: A push and a pop of a non-empty queue in the same cycle leave the count unchanged; both pointers advance and the order is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access this cycle |
| bus_wr | input | 1 | 1 write, 0 read |
| bus_addr | input | AW (12) | Byte address, bits 1:0 ignored |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| bus_err | output | 1 | One-cycle pulse after an unmapped access |
| rx_push | input | 1 | Offer a received item |
| rx_char | input | 8 | Received character |
| rx_brk | input | 1 | Item is a break event |
| rx_ready | output | 1 | A push this cycle is accepted |
| tx_strobe | output | 1 | Transmit byte valid |
| tx_byte | output | 8 | Transmit byte |
| irq | output | 1 | Interrupt, raw AND mask non-zero |

## Verification
The bench builds the block with its default parameters: DEPTH 16, TRIG 1, 16-bit configuration words, a 12-bit address and the default identification bytes. A depth of 16 lets the bench fill the queue completely after a holding-mode exchange has left the read pointer off zero. The full-flag edge and the pointer wrap are therefore both reached in a few dozen cycles. With TRIG at 1, the receive interrupt's set and clear points are the empty/non-empty boundary, which every directed scenario crosses.

// File: rtl/uart_regfront_pkg.sv
package uart_regfront_pkg;
  localparam int WORD_DATA  = 0;
  localparam int WORD_FLAGS = 6;
  localparam int WORD_LPDIV = 8;
  localparam int WORD_IBAUD = 9;
  localparam int WORD_FBAUD = 10;
  localparam int WORD_LINE  = 11;
  localparam int WORD_CTRL  = 12;
  localparam int WORD_LEVEL = 13;
  localparam int WORD_MASK  = 14;
  localparam int WORD_RAW   = 15;
  localparam int WORD_MIS   = 16;
  localparam int WORD_CLR   = 17;
  localparam int WORD_DMA   = 18;
  localparam int WORD_ID0   = 'h3F8;

  localparam int ENTRY_W    = 11;
  localparam int BIT_RXIRQ  = 4;
  localparam int BIT_TXIRQ  = 5;
  localparam int BIT_QUEUE  = 4;

  // circular slot arithmetic, kept here so the bench can restate it
  function automatic int ring_slot(int base, int offs, int depth);
    int s;
    s = base + offs;
    if (s >= depth) s = s - depth;
    return s;
  endfunction

  function automatic logic [ENTRY_W-1:0] rx_entry(logic brk, logic [7:0] ch);
    return brk ? ENTRY_W'(11'h400) : {3'b000, ch};
  endfunction

  function automatic logic [7:0] id_byte(logic [63:0] tbl, logic [2:0] idx);
    return tbl[{idx, 3'b000} +: 8];
  endfunction

  function automatic logic [7:0] flag_word(logic rx_full, logic rx_empty);
    return {1'b1, rx_full, 1'b0, rx_empty, 4'b0000};
  endfunction
endpackage

// File: rtl/uart_rxq.sv
module uart_rxq
  import uart_regfront_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int EW    = 11
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         push,
  input  logic [EW-1:0]                push_word,
  input  logic                         pop,
  output logic [EW-1:0]                head,
  output logic [$clog2(DEPTH+1)-1:0]   count,
  output logic [$clog2(DEPTH+1)-1:0]   count_nxt
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH+1);

  logic [EW-1:0] mem [DEPTH];
  logic [PW-1:0] rd_ptr;
  logic [PW-1:0] wr_slot;
  logic [PW-1:0] rd_next;
  logic          dec;

  assign dec       = pop && (count != '0);
  assign count_nxt = count + CW'(push) - CW'(dec);
  assign wr_slot   = PW'(ring_slot(int'(rd_ptr), int'(count), DEPTH));
  assign rd_next   = PW'(ring_slot(int'(rd_ptr), 1, DEPTH));
  assign head      = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push) mem[wr_slot] <= push_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      count <= count_nxt;
      if (dec) rd_ptr <= rd_next;
    end
  end
endmodule

// File: rtl/uart_irqctl.sv
module uart_irqctl
  import uart_regfront_pkg::*;
#(
  parameter int TRIG = 1,
  parameter int CW   = 5,
  parameter int RW   = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_push,
  input  logic          rx_pop,
  input  logic [CW-1:0] cnt_nxt,
  input  logic          tx_evt,
  input  logic          mask_we,
  input  logic [RW-1:0] mask_wd,
  input  logic          clr_we,
  input  logic [RW-1:0] clr_wd,
  output logic [RW-1:0] raw_word,
  output logic [RW-1:0] mask_q,
  output logic [RW-1:0] masked,
  output logic          irq
);
  logic raw_rx, raw_tx;
  logic rx_set, rx_clr;

  assign rx_set = rx_push && (cnt_nxt == CW'(TRIG));
  assign rx_clr = (rx_pop && (cnt_nxt == CW'(TRIG - 1))) || (clr_we && clr_wd[BIT_RXIRQ]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_rx <= 1'b0;
      raw_tx <= 1'b0;
      mask_q <= '0;
    end else begin
      if (rx_set)      raw_rx <= 1'b1;
      else if (rx_clr) raw_rx <= 1'b0;
      if (tx_evt)                         raw_tx <= 1'b1;
      else if (clr_we && clr_wd[BIT_TXIRQ]) raw_tx <= 1'b0;
      if (mask_we) mask_q <= mask_wd;
    end
  end

  always_comb begin
    raw_word            = '0;
    raw_word[BIT_RXIRQ] = raw_rx;
    raw_word[BIT_TXIRQ] = raw_tx;
  end

  assign masked = raw_word & mask_q;
  assign irq    = |masked;
endmodule

// File: rtl/uart_regfront.sv
module uart_regfront
  import uart_regfront_pkg::*;
#(
  parameter int          AW       = 12,
  parameter int          DEPTH    = 16,
  parameter int          TRIG     = 1,
  parameter int          RW       = 16,
  parameter logic [63:0] ID_BYTES = 64'hE419A35C_00073021
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  output logic          bus_err,
  input  logic          rx_push,
  input  logic [7:0]    rx_char,
  input  logic          rx_brk,
  output logic          rx_ready,
  output logic          tx_strobe,
  output logic [7:0]    tx_byte,
  output logic          irq
);
  localparam int CW = $clog2(DEPTH+1);

  logic [31:0]      widx;
  logic             rd, wr, is_id, mapped;
  logic             push_ok, pop_req, fifo_en;
  logic [ENTRY_W-1:0] q_head;
  logic [CW-1:0]    q_count, q_count_nxt;
  logic             rxe_q, rxf_q;
  logic [RW-1:0]    lpdiv, ibaud, fbaud, line, ctrl, level, dma;
  logic [RW-1:0]    raw_word, mask_q, masked;

  assign widx    = 32'(bus_addr[AW-1:2]);
  assign rd      = bus_sel && !bus_wr;
  assign wr      = bus_sel && bus_wr;
  assign is_id   = widx >= WORD_ID0;
  assign mapped  = is_id || widx == WORD_DATA || widx == WORD_FLAGS ||
                   (widx >= WORD_LPDIV && widx <= WORD_DMA);
  assign fifo_en = line[BIT_QUEUE];
  assign rx_ready = fifo_en ? (q_count < CW'(DEPTH)) : (q_count == '0);
  assign push_ok = rx_push && rx_ready;
  assign pop_req = rd && widx == WORD_DATA;

  uart_rxq #(.DEPTH(DEPTH), .EW(ENTRY_W)) u_rxq (
    .clk(clk), .rst_n(rst_n), .push(push_ok),
    .push_word(rx_entry(rx_brk, rx_char)), .pop(pop_req),
    .head(q_head), .count(q_count), .count_nxt(q_count_nxt)
  );

  uart_irqctl #(.TRIG(TRIG), .CW(CW), .RW(RW)) u_irq (
    .clk(clk), .rst_n(rst_n), .rx_push(push_ok), .rx_pop(pop_req),
    .cnt_nxt(q_count_nxt), .tx_evt(wr && widx == WORD_DATA),
    .mask_we(wr && widx == WORD_MASK), .mask_wd(bus_wdata[RW-1:0]),
    .clr_we(wr && widx == WORD_CLR), .clr_wd(bus_wdata[RW-1:0]),
    .raw_word(raw_word), .mask_q(mask_q), .masked(masked), .irq(irq)
  );

  // configuration words
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lpdiv <= '0;
      ibaud <= '0;
      fbaud <= '0;
      line  <= '0;
      ctrl  <= RW'(16'h0300);
      level <= RW'(16'h0012);
      dma   <= '0;
    end else if (wr) begin
      case (widx)
        WORD_LPDIV: lpdiv <= bus_wdata[RW-1:0];
        WORD_IBAUD: ibaud <= bus_wdata[RW-1:0];
        WORD_FBAUD: fbaud <= bus_wdata[RW-1:0];
        WORD_LINE:  line  <= bus_wdata[RW-1:0];
        WORD_CTRL:  ctrl  <= bus_wdata[RW-1:0];
        WORD_LEVEL: level <= bus_wdata[RW-1:0];
        WORD_DMA:   dma   <= bus_wdata[RW-1:0];
        default: ;
      endcase
    end
  end

  // receive flags, transmit strobe, error pulse
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxe_q     <= 1'b1;
      rxf_q     <= 1'b0;
      tx_strobe <= 1'b0;
      tx_byte   <= '0;
      bus_err   <= 1'b0;
    end else begin
      if (push_ok || pop_req) rxe_q <= (q_count_nxt == '0);
      if (push_ok && (q_count_nxt == CW'(DEPTH) || ctrl[BIT_QUEUE])) rxf_q <= 1'b1;
      else if (pop_req)                                           rxf_q <= 1'b0;
      tx_strobe <= wr && widx == WORD_DATA;
      if (wr && widx == WORD_DATA) tx_byte <= bus_wdata[7:0];
      bus_err <= bus_sel && !mapped;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (rd) begin
      if (is_id) bus_rdata = {24'b0, id_byte(ID_BYTES, widx[2:0])};
      else begin
        case (widx)
          WORD_DATA:  bus_rdata = 32'(q_head);
          WORD_FLAGS: bus_rdata = {24'b0, flag_word(rxf_q, rxe_q)};
          WORD_LPDIV: bus_rdata = 32'(lpdiv);
          WORD_IBAUD: bus_rdata = 32'(ibaud);
          WORD_FBAUD: bus_rdata = 32'(fbaud);
          WORD_LINE:  bus_rdata = 32'(line);
          WORD_CTRL:  bus_rdata = 32'(ctrl);
          WORD_LEVEL: bus_rdata = 32'(level);
          WORD_MASK:  bus_rdata = 32'(mask_q);
          WORD_RAW:   bus_rdata = 32'(raw_word);
          WORD_MIS:   bus_rdata = 32'(masked);
          WORD_DMA:   bus_rdata = 32'(dma);
          default:    bus_rdata = '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/uart_regfront_chk.sv
module uart_regfront_chk #(
  parameter int DEPTH = 16,
  parameter int TRIG  = 1,
  parameter int RW    = 16
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic [$clog2(DEPTH+1)-1:0] q_count,
  input logic                       push_ok,
  input logic                       pop_req,
  input logic                       fifo_en,
  input logic                       rxe_q,
  input logic                       tx_strobe,
  input logic [RW-1:0]              raw_word,
  input logic                       bus_err,
  input logic                       bus_sel
);
  localparam int CW = $clog2(DEPTH+1);

  AST_COUNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    q_count <= CW'(DEPTH)); // R1
  AST_HOLD_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (push_ok && !fifo_en) |-> q_count == '0); // R2
  AST_POP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_req && !push_ok && q_count != '0) |=> q_count == CW'($past(q_count) - 1'b1)); // R3
  AST_EMPTY_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    rxe_q == (q_count == '0)); // R4
  AST_RX_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (push_ok && !pop_req && q_count == CW'(TRIG - 1)) |=> raw_word[4]); // R6
  AST_TX_RAW: assert property (@(posedge clk) disable iff (!rst_n)
    tx_strobe |-> raw_word[5]); // R8
  AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> $past(bus_sel)); // R12
  AST_BOTH_WAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (push_ok && pop_req && q_count != '0) |=> $stable(q_count)); // R13
endmodule

bind uart_regfront uart_regfront_chk #(.DEPTH(DEPTH), .TRIG(TRIG), .RW(RW)) u_chk (
  .clk(clk), .rst_n(rst_n), .q_count(q_count), .push_ok(push_ok),
  .pop_req(pop_req), .fifo_en(fifo_en), .rxe_q(rxe_q), .tx_strobe(tx_strobe),
  .raw_word(raw_word), .bus_err(bus_err), .bus_sel(bus_sel)
);

// File: tb/uart_regfront_test.sv
`timescale 1ns/100ps
module uart_regfront_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_err, rx_ready, tx_strobe, irq;
  logic        rx_push = 1'b0, rx_brk = 1'b0;
  logic [7:0]  rx_char = '0, tx_byte;

  int checks = 0, failures = 0;
  logic [31:0] rd_val;
  logic        seen_err, seen_tx;
  logic [7:0]  seen_byte;

  always #2.5 clk = ~clk;

  uart_regfront uut (.*);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(int word, logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 12'(word * 4); bus_wdata = d;
    @(posedge clk); #1;
    seen_err = bus_err; seen_tx = tx_strobe; seen_byte = tx_byte;
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read_addr(logic [11:0] a);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 rd_val = bus_rdata;
    @(posedge clk); #1;
    seen_err = bus_err;
    bus_sel = 1'b0;
  endtask

  task automatic bus_read(int word);
    bus_read_addr(12'(word * 4));
  endtask

  task automatic push(logic [7:0] c, logic brk);
    @(negedge clk);
    rx_push = 1'b1; rx_char = c; rx_brk = brk;
    @(posedge clk); #1;
    rx_push = 1'b0; rx_brk = 1'b0;
  endtask

  task automatic t_reset;
    bus_read(6);  check("R4 flags after reset", rd_val, 32'h90);
    bus_read(12); check("R10 control reset", rd_val, 32'h300);
    bus_read(13); check("R10 level reset", rd_val, 32'h12);
    check("R9 irq low after reset", irq, 1'b0);
    check("R2 ready after reset", rx_ready, 1'b1);
  endtask

  task automatic t_holding;
    push(8'h41, 1'b0);
    check("R2 not ready while holding one", rx_ready, 1'b0);
    push(8'h42, 1'b0);
    bus_read(0); check("R3 holding read", rd_val, 32'h41);
    bus_read(6); check("R4 empty after holding read", rd_val, 32'h90);
    bus_read(0); bus_read(6); check("R3 empty read leaves queue empty", rd_val, 32'h90);
  endtask

  task automatic t_fifo_fill;
    bus_write(11, 32'h10);
    for (int i = 0; i < 16; i++) push(8'(8'h60 + i), 1'b0);
    bus_read(6); check("R5 full flag at depth", rd_val, 32'hC0);
    check("R1 not ready when full", rx_ready, 1'b0);
    push(8'h99, 1'b0);
    for (int i = 0; i < 16; i++) begin
      bus_read(0); check("R1 order and wrap", rd_val, 32'(8'h60 + i));
    end
    bus_read(6); check("R5 full cleared by read", rd_val, 32'h90);
    bus_read(15); check("R6 raw rx clear after drain", rd_val, 32'h0);
  endtask

  task automatic t_break;
    push(8'h77, 1'b1);
    bus_read(0); check("R7 break entry", rd_val, 32'h400);
    push(8'hFE, 1'b0);
    bus_read(0); check("R7 char entry", rd_val, 32'hFE);
  endtask

  task automatic t_irq;
    bus_write(14, 32'h30);
    push(8'h33, 1'b0);
    bus_read(15); check("R6 raw rx set", rd_val, 32'h10);
    bus_read(16); check("R9 masked status", rd_val, 32'h10);
    check("R9 irq high", irq, 1'b1);
    bus_read(0);
    bus_read(15); check("R6 raw rx clear on pop", rd_val, 32'h0);
    check("R9 irq low", irq, 1'b0);
    bus_write(0, 32'h1235A);
    check("R8 tx strobe", seen_tx, 1'b1);
    check("R8 tx byte", seen_byte, 8'h5A);
    @(posedge clk); #1; check("R8 strobe one cycle", tx_strobe, 1'b0);
    bus_read(15); check("R8 raw tx set", rd_val, 32'h20);
    bus_write(14, 32'h10); check("R9 masked off", irq, 1'b0);
    push(8'h34, 1'b0);
    bus_write(17, 32'h20);
    bus_read(15); check("R9 clear only written bits", rd_val, 32'h10);
    bus_write(17, 32'h10);
    bus_read(15); check("R9 clear rx bit", rd_val, 32'h0);
    bus_read(0);
  endtask

  task automatic t_same_cycle;
    push(8'h11, 1'b0); push(8'h12, 1'b0);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 12'h000;
    rx_push = 1'b1; rx_char = 8'h13;
    #1 rd_val = bus_rdata;
    @(posedge clk); #1;
    bus_sel = 1'b0; rx_push = 1'b0;
    check("R13 head during push", rd_val, 32'h11);
    bus_read(0); check("R13 second", rd_val, 32'h12);
    bus_read(0); check("R13 third", rd_val, 32'h13);
    bus_read(6); check("R13 empty after", rd_val, 32'h90);
  endtask

  task automatic t_ctrl_full;
    bus_write(12, 32'h310);
    push(8'h01, 1'b0);
    bus_read(6); check("R5 full via control bit", rd_val, 32'hC0);
    bus_read(0); check("R5 data", rd_val, 32'h01);
    bus_read(6); check("R5 cleared by read", rd_val, 32'h90);
    bus_write(12, 32'h300);
  endtask

  task automatic t_config;
    bus_write(9, 32'h1234);  bus_read(9);  check("R10 integer divisor", rd_val, 32'h1234);
    bus_write(10, 32'hABCDE); bus_read(10); check("R10 16-bit storage", rd_val, 32'hBCDE);
    bus_write(8, 32'h55);    bus_read(8);  check("R10 low-power divisor", rd_val, 32'h55);
    bus_write(18, 32'h3);    bus_read(18); check("R10 dma control", rd_val, 32'h3);
    bus_write(6, 32'h0);
    check("R4 flag write no error", seen_err, 1'b0);
    bus_read(6); check("R4 flag write ignored", rd_val, 32'h90);
  endtask

  task automatic t_unmapped;
    bus_read(2); check("R12 unmapped reads zero", rd_val, 32'h0);
    check("R12 error pulse on read", seen_err, 1'b1);
    bus_write(7, 32'hFF);
    check("R12 error pulse on write", seen_err, 1'b1);
    @(posedge clk); #1; check("R12 pulse one cycle", bus_err, 1'b0);
    bus_read(17); check("R12 clear word reads zero", rd_val, 32'h0);
    check("R12 clear word no error", seen_err, 1'b0);
  endtask

  task automatic t_id;
    bus_read_addr(12'hFE0); check("R11 id byte 0", rd_val, 32'h21);
    bus_read_addr(12'hFF0); check("R11 id byte 4", rd_val, 32'h5C);
    bus_read_addr(12'hFFC); check("R11 id byte 7", rd_val, 32'hE4);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_holding;
    t_fifo_fill;
    t_break;
    t_irq;
    t_same_cycle;
    t_ctrl_full;
    t_config;
    t_unmapped;
    t_id;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule